// File: doc/BRIEF.md
# R1B Busy Completion Interrupt Synthesizer

This block sits beside an SD host controller core whose completion interrupts for busy-signalling commands arrive too early: the core reports the command or the transfer as finished while the card is still holding DAT0 low. The block snoops the command-flag and transfer-mode register writes to learn when such a command is being issued. It then watches the core's raw interrupt status for the one completion bit that matters for that command.

When that bit appears while the card is still busy, the block clears it in the core and hides it from software. It then samples the busy indication once per millisecond tick. When the card releases the line, it raises a synthesized data-end completion, plus a response-complete bit for commands that carry no data. If the deadline passes first, it raises a data-timeout bit instead. Software reads a merged status: the core status ORed with the synthesized bits. Writing ones to that status register clears the matching synthesized bits and forwards the same write to the core.

Top module: `r1b_busy_fixer`

## Requirements
- R1: A command write (`cmd_wr_i`) with the data-present flag (bit 5) clear and response type bits [1:0] equal to 2'b11 arms no-data mode. `resp_en_force_o` is high exactly while no-data mode is armed.
- R2: A command write with bit 5 set arms auto-stop mode only if the last transfer-mode write had both bit 2 (automatic stop) and bit 5 (multi-block) set. Any other command write leaves the mode unchanged.
- R3: No-data mode watches status bit 0 (response complete). Auto-stop mode watches status bit 1 (data end). With no mode armed, nothing is intercepted and `core_wr_o` stays low.
- R4: The card is busy while `dat_active_i` or `dat_inhibit_i` is high. Either one alone counts as busy.
- R5: If the watched bit is set while the card is busy, `core_wr_o` pulses in that same cycle with only the watched bit in `core_wdata_o`. The watched bit reads as 0 in `stat_o` from that cycle until the outcome.
- R6: After an interception, busy is sampled once every CLK_HZ/TICK_HZ cycles. The first sample where the card is idle completes the command; that sample falls on the cycle that is a multiple of the tick period after the interception.
- R7: If the card is still busy at tick number DEADLINE_TICKS, data-timeout (bit 20) is set instead of data-end.
- R8: A completion sets data-end (bit 1). In no-data mode it also sets response-complete (bit 0).
- R9: After either outcome the mode returns to none. Command writes made while waiting have no effect on the mode.
- R10: If the card is idle when the watched bit appears, the synthesized bits are set on the next cycle and no write goes to the core.
- R11: `stat_o` is the core status ORed with the synthesized bits. A host write (`reg_wr_i`) is forwarded to the core in the same cycle and clears the synthesized bits written as one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_wr_i | input | 1 | Command-flag register write strobe |
| cmd_flags_i | input | 16 | Command-flag write data |
| xfer_wr_i | input | 1 | Transfer-mode register write strobe |
| xfer_mode_i | input | 16 | Transfer-mode write data |
| core_stat_i | input | 32 | Raw interrupt status from the core |
| dat_active_i | input | 1 | Present-state data-line-active bit |
| dat_inhibit_i | input | 1 | Present-state data-inhibit bit |
| reg_wr_i | input | 1 | Host write strobe to the interrupt status |
| reg_wdata_i | input | 32 | Host write-one-to-clear data |
| stat_o | output | 32 | Merged interrupt status seen by software |
| core_wr_o | output | 1 | Write strobe to the core interrupt status |
| core_wdata_o | output | 32 | Write-one-to-clear data for the core |
| resp_en_force_o | output | 1 | Forces the response interrupt enable on |

## Verification
The bench sweeps the cycle at which busy releases across every position of a shortened tick period and deadline, in both modes. This catches an off-by-one in the tick prescaler or in the deadline counter: a wrong design completes one tick early or late, or reports a timeout where the last tick should still have completed. Busy is driven alternately from each of the two present-state bits, so a design that tests only one of them completes while the card is still busy. The bench also checks that a command written during the wait does not re-arm the block, since a design that accepts it would intercept a later unrelated completion. It checks that an idle card completes at once without touching the core, and that clearing one synthesized bit leaves the others in place.

// File: rtl/r1b_fix_pkg.sv
package r1b_fix_pkg;
  localparam int STAT_W      = 32;
  localparam int ST_RESP     = 0;
  localparam int ST_DEND     = 1;
  localparam int ST_DTO      = 20;
  localparam int CF_DATA     = 5;
  localparam int XM_AUTOSTOP = 2;
  localparam int XM_MULTI    = 5;

  typedef enum logic [1:0] {
    FIX_NONE     = 2'd0,
    FIX_NODATA   = 2'd1,
    FIX_AUTOSTOP = 2'd2
  } fix_mode_e;
endpackage

// File: rtl/r1b_tick.sv
module r1b_tick #(
  parameter int DIV = 100000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] pre_q;

  assign tick_o = (pre_q == CW'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pre_q <= '0;
    else if (clr_i)   pre_q <= '0;
    else if (en_i)    pre_q <= tick_o ? '0 : pre_q + CW'(1);
  end
endmodule

// File: rtl/r1b_arm.sv
module r1b_arm
  import r1b_fix_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cmd_wr_i,
  input  logic [15:0] cmd_flags_i,
  input  logic        xfer_wr_i,
  input  logic [15:0] xfer_mode_i,
  input  logic        waiting_i,
  input  logic        finish_i,
  output fix_mode_e   mode_o
);
  logic      auto_q, multi_q;
  fix_mode_e mode_q;
  logic      unused_bits;

  assign unused_bits = ^{cmd_flags_i[15:6], cmd_flags_i[4:2],
                         xfer_mode_i[15:6], xfer_mode_i[4:3], xfer_mode_i[1:0]};
  assign mode_o = mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      auto_q  <= 1'b0;
      multi_q <= 1'b0;
    end else if (xfer_wr_i) begin
      auto_q  <= xfer_mode_i[XM_AUTOSTOP];
      multi_q <= xfer_mode_i[XM_MULTI];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= FIX_NONE;
    else if (finish_i) mode_q <= FIX_NONE;
    else if (cmd_wr_i && !waiting_i) begin
      if (cmd_flags_i[CF_DATA]) begin
        if (auto_q && multi_q) mode_q <= FIX_AUTOSTOP;
      end else if (cmd_flags_i[1:0] == 2'b11) begin
        mode_q <= FIX_NODATA;
      end
    end
  end
endmodule

// File: rtl/r1b_wait.sv
module r1b_wait
  import r1b_fix_pkg::*;
#(
  parameter int DEADLINE_TICKS = 250
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  fix_mode_e         mode_i,
  input  logic [STAT_W-1:0] core_stat_i,
  input  logic              busy_i,
  input  logic              tick_i,
  output logic              waiting_o,
  output logic              clr_o,
  output logic [STAT_W-1:0] watch_o,
  output logic [STAT_W-1:0] set_o,
  output logic              finish_o
);
  localparam int DLW = $clog2(DEADLINE_TICKS + 1);

  logic           wait_q;
  logic [DLW-1:0] dl_q;
  logic           hit, done_ok, tmo;

  always_comb begin
    watch_o = '0;
    case (mode_i)
      FIX_NODATA:   watch_o[ST_RESP] = 1'b1;
      FIX_AUTOSTOP: watch_o[ST_DEND] = 1'b1;
      default:      watch_o = '0;
    endcase
  end

  assign hit     = !wait_q && |(core_stat_i & watch_o);
  assign clr_o   = hit && busy_i;
  assign done_ok = (hit && !busy_i) || (wait_q && tick_i && !busy_i);
  assign tmo     = wait_q && tick_i && busy_i && (dl_q == DLW'(DEADLINE_TICKS - 1));
  assign finish_o  = done_ok || tmo;
  assign waiting_o = wait_q;

  always_comb begin
    set_o = '0;
    if (done_ok) begin
      set_o[ST_DEND] = 1'b1;
      set_o[ST_RESP] = (mode_i == FIX_NODATA);
    end else if (tmo) begin
      set_o[ST_DTO] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_q <= 1'b0;
      dl_q   <= '0;
    end else if (clr_o) begin
      wait_q <= 1'b1;
      dl_q   <= '0;
    end else begin
      if (finish_o)              wait_q <= 1'b0;
      if (wait_q && tick_i)      dl_q   <= dl_q + DLW'(1);
    end
  end
endmodule

// File: rtl/r1b_merge.sv
module r1b_merge
  import r1b_fix_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STAT_W-1:0] core_stat_i,
  input  logic [STAT_W-1:0] hide_i,
  input  logic [STAT_W-1:0] set_i,
  input  logic              reg_wr_i,
  input  logic [STAT_W-1:0] reg_wdata_i,
  output logic [STAT_W-1:0] synth_o,
  output logic [STAT_W-1:0] stat_o
);
  logic [STAT_W-1:0] synth_q, wclr;

  assign wclr    = reg_wr_i ? reg_wdata_i : '0;
  assign synth_o = synth_q;
  assign stat_o  = (core_stat_i & ~hide_i) | synth_q;

  // a new set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) synth_q <= '0;
    else         synth_q <= (synth_q & ~wclr) | set_i;
  end
endmodule

// File: rtl/r1b_busy_fixer.sv
module r1b_busy_fixer
  import r1b_fix_pkg::*;
#(
  parameter int CLK_HZ         = 100_000_000,
  parameter int TICK_HZ        = 1000,
  parameter int DEADLINE_TICKS = 250
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cmd_wr_i,
  input  logic [15:0] cmd_flags_i,
  input  logic        xfer_wr_i,
  input  logic [15:0] xfer_mode_i,
  input  logic [31:0] core_stat_i,
  input  logic        dat_active_i,
  input  logic        dat_inhibit_i,
  input  logic        reg_wr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] stat_o,
  output logic        core_wr_o,
  output logic [31:0] core_wdata_o,
  output logic        resp_en_force_o
);
  localparam int DIV = (CLK_HZ / TICK_HZ > 0) ? CLK_HZ / TICK_HZ : 1;

  fix_mode_e         mode_w;
  logic              busy_w, tick_w, waiting_w, clr_w, finish_w;
  logic [STAT_W-1:0] watch_w, set_w, hide_w, synth_w;

  assign busy_w = dat_active_i | dat_inhibit_i;
  assign hide_w = watch_w & {STAT_W{waiting_w | clr_w}};

  r1b_arm i_arm (
    .clk_i, .rst_ni, .cmd_wr_i, .cmd_flags_i, .xfer_wr_i, .xfer_mode_i,
    .waiting_i(waiting_w), .finish_i(finish_w), .mode_o(mode_w)
  );

  r1b_tick #(.DIV(DIV)) i_tick (
    .clk_i, .rst_ni, .clr_i(clr_w), .en_i(waiting_w), .tick_o(tick_w)
  );

  r1b_wait #(.DEADLINE_TICKS(DEADLINE_TICKS)) i_wait (
    .clk_i, .rst_ni, .mode_i(mode_w), .core_stat_i, .busy_i(busy_w),
    .tick_i(tick_w), .waiting_o(waiting_w), .clr_o(clr_w),
    .watch_o(watch_w), .set_o(set_w), .finish_o(finish_w)
  );

  r1b_merge i_merge (
    .clk_i, .rst_ni, .core_stat_i, .hide_i(hide_w), .set_i(set_w),
    .reg_wr_i, .reg_wdata_i, .synth_o(synth_w), .stat_o
  );

  assign core_wr_o       = reg_wr_i | clr_w;
  assign core_wdata_o    = (reg_wr_i ? reg_wdata_i : '0) | (clr_w ? watch_w : '0);
  assign resp_en_force_o = (mode_w == FIX_NODATA);
endmodule

// File: rtl/r1b_busy_fixer_chk.sv
module r1b_busy_fixer_chk
  import r1b_fix_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              dat_active_i,
  input logic              dat_inhibit_i,
  input logic              reg_wr_i,
  input logic [31:0]       reg_wdata_i,
  input logic              core_wr_o,
  input logic [31:0]       core_wdata_o,
  input fix_mode_e         mode_i,
  input logic              waiting_i,
  input logic              finish_i,
  input logic [STAT_W-1:0] set_i,
  input logic [STAT_W-1:0] synth_i
);
  AST_CORE_CLR_STARTS_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_wr_o && !reg_wr_i) |=> waiting_i); // R5

  AST_NO_REARM_WHILE_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (waiting_i && !finish_i) |=> $stable(mode_i)); // R9

  AST_MODE_NONE_AFTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    finish_i |=> (mode_i == FIX_NONE)); // R9

  AST_TIMEOUT_ONLY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(synth_i[ST_DTO]) |-> $past(dat_active_i | dat_inhibit_i)); // R7

  AST_HOST_WRITE_FWD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_i |-> (core_wr_o && ((core_wdata_o & reg_wdata_i) == reg_wdata_i))); // R11

  AST_W1C_DEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_wdata_i[ST_DEND] && !set_i[ST_DEND]) |=> !synth_i[ST_DEND]); // R11
endmodule

bind r1b_busy_fixer r1b_busy_fixer_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .dat_active_i(dat_active_i),
  .dat_inhibit_i(dat_inhibit_i), .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i),
  .core_wr_o(core_wr_o), .core_wdata_o(core_wdata_o), .mode_i(mode_w),
  .waiting_i(waiting_w), .finish_i(finish_w), .set_i(set_w), .synth_i(synth_w)
);

// File: tb/test_r1b_busy_fixer.sv
module test_r1b_busy_fixer;
  localparam int CLK_HZ = 4;
  localparam int TICK_HZ = 1;
  localparam int DL = 3;
  localparam int DIV = CLK_HZ / TICK_HZ;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cmd_wr = 1'b0, xfer_wr = 1'b0, dla = 1'b0, inh = 1'b0, reg_wr = 1'b0;
  logic [15:0] flags = '0, xfer = '0;
  logic [31:0] core_stat = '0, wdata = '0;
  logic [31:0] stat, core_wdata;
  logic        core_wr, force_en;
  int n_tot = 0, n_bad = 0;

  always #10 clk = ~clk;

  r1b_busy_fixer #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ), .DEADLINE_TICKS(DL)) i_r1b_busy_fixer (
    .clk_i(clk), .rst_ni(rst_n), .cmd_wr_i(cmd_wr), .cmd_flags_i(flags),
    .xfer_wr_i(xfer_wr), .xfer_mode_i(xfer), .core_stat_i(core_stat),
    .dat_active_i(dla), .dat_inhibit_i(inh), .reg_wr_i(reg_wr), .reg_wdata_i(wdata),
    .stat_o(stat), .core_wr_o(core_wr), .core_wdata_o(core_wdata),
    .resp_en_force_o(force_en)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tot++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic cmd(logic [15:0] f);
    @(negedge clk); cmd_wr = 1'b1; flags = f;
    @(negedge clk); cmd_wr = 1'b0;
  endtask

  task automatic xmode(logic [15:0] x);
    @(negedge clk); xfer_wr = 1'b1; xfer = x;
    @(negedge clk); xfer_wr = 1'b0;
  endtask

  task automatic host_clr(logic [31:0] m);
    @(negedge clk); reg_wr = 1'b1; wdata = m; #1;
    chk("R11 fwd strobe", {31'd0, core_wr}, 32'd1);
    chk("R11 fwd data", core_wdata, m);
    @(negedge clk); reg_wr = 1'b0; #1;
  endtask

  // with no mode armed the watched bit must pass through untouched
  task automatic expect_idle(logic [31:0] bitm, string req);
    @(negedge clk); core_stat = bitm; dla = 1'b1; #1;
    chk(req, {31'd0, core_wr}, 32'd0);
    @(negedge clk); #1;
    chk(req, stat, bitm);
    core_stat = '0; dla = 1'b0;
  endtask

  task automatic run_case(bit nodata, int m);
    logic [31:0] w, expv;
    int found, k, exp_j;
    if (nodata) cmd(16'h0003);
    else begin xmode(16'h0024); cmd(16'h0022); end
    #1;
    chk("R1 force", {31'd0, force_en}, {31'd0, nodata});
    w = nodata ? 32'h1 : 32'h2;
    if (m % 2 == 0) dla = 1'b1; else inh = 1'b1;   // R4 either bit alone
    core_stat = w; #1;
    chk("R5 core clear strobe", {31'd0, core_wr}, 32'd1);
    chk("R5 core clear data", core_wdata, w);
    chk("R5 hidden", stat, 32'd0);
    @(posedge clk); @(negedge clk);
    core_stat = '0;
    if (m == 0) begin dla = 1'b0; inh = 1'b0; end
    found = -1;
    for (int j = 1; j <= DIV * DL + 2; j++) begin
      @(posedge clk); @(negedge clk); #1;
      if (stat != 0) begin found = j; break; end
      if (j == m) begin dla = 1'b0; inh = 1'b0; end
    end
    k = m / DIV + 1;
    exp_j = (k <= DL) ? k * DIV : DL * DIV;
    expv = (k <= DL) ? (nodata ? 32'h3 : 32'h2) : 32'h0010_0000;
    chk("R6 poll cycle", found, exp_j);
    chk((k <= DL) ? "R8 done bits" : "R7 timeout bit", stat, expv);
    chk("R9 force cleared", {31'd0, force_en}, 32'd0);
    dla = 1'b0; inh = 1'b0;
    host_clr(expv);
    chk("R11 cleared", stat, 32'd0);
    expect_idle(w, "R9 mode none");
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R11 reset stat", stat, 32'd0);
    chk("R1 reset force", {31'd0, force_en}, 32'd0);
    chk("R3 reset no write", {31'd0, core_wr}, 32'd0);
    rst_n = 1'b1;
    expect_idle(32'h1, "R3 none ignores resp");
    expect_idle(32'h2, "R3 none ignores dend");

    // arming negatives
    cmd(16'h0002); #1;
    chk("R1 short no busy", {31'd0, force_en}, 32'd0);
    expect_idle(32'h1, "R1 not armed");
    xmode(16'h0020); cmd(16'h0022);
    expect_idle(32'h2, "R2 multi only");
    xmode(16'h0004); cmd(16'h0022);
    expect_idle(32'h2, "R2 autostop only");

    // exhaustive release position sweep, both modes
    for (int md = 0; md < 2; md++)
      for (int m = 0; m <= DIV * DL + 1; m++)
        run_case(md[0], m);

    // immediate completion, no-data, with an unrelated core bit
    cmd(16'h0003);
    @(negedge clk); core_stat = 32'h81; #1;
    chk("R10 no core write", {31'd0, core_wr}, 32'd0);
    @(negedge clk); #1;
    chk("R10 immediate stat", stat, 32'h83);
    chk("R9 force off", {31'd0, force_en}, 32'd0);
    core_stat = '0;
    host_clr(32'h2); chk("R11 partial clear", stat, 32'h1);
    host_clr(32'h1); chk("R11 full clear", stat, 32'h0);

    // immediate completion, auto-stop
    xmode(16'h0024); cmd(16'h0022);
    @(negedge clk); core_stat = 32'h2; #1;
    chk("R10 no core write as", {31'd0, core_wr}, 32'd0);
    @(negedge clk); #1;
    chk("R10 immediate stat as", stat, 32'h2);
    core_stat = '0;
    host_clr(32'h2);
    chk("R11 clear as", stat, 32'h0);

    // command written during the wait is ignored
    cmd(16'h0003);
    @(negedge clk); core_stat = 32'h1; inh = 1'b1;
    @(negedge clk); core_stat = '0;
    xmode(16'h0024); cmd(16'h0022);
    inh = 1'b0;
    repeat (DIV + 1) @(negedge clk);
    #1;
    chk("R8 wait done", stat, 32'h3);
    host_clr(32'h3);
    expect_idle(32'h2, "R9 no rearm in wait");

    $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
    $finish;
  end
endmodule